// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a byte-wide mailbox that sits as a slave on a host bus and lets the host reach a second register bus that the host cannot address directly. The host fills in a 16-bit target address (as a high byte and a low byte) and, for writes, a data byte. It then writes a command byte that launches exactly one downstream read or write. While that transfer is pending, a status byte reports it as busy. Once status reads back as idle, the host collects the returned byte of a read from the read-data register.

The downstream side is a plain request/acknowledge byte bus. The bridge raises a request together with a direction, an address and write data, and holds them until the target acknowledges. If no acknowledge arrives within a parameterised number of cycles, the bridge gives up and returns to idle, and an abandoned read yields 0xFF. The address and data registers keep their contents after a transfer, so repeating an access takes one command write.

Top module: `ind_reg_bridge`

## Requirements
- R1: Host offsets are decoded on `host_off`. Offset 0 holds the address low byte, offset 1 the address high byte, offset 2 the write data, offset 3 the read data and offset 5 the status. Offsets 0, 1 and 2 read back what was last written to them. Offset 4 (command) and offsets 6 and 7 read as 0x00.
- R2: While the bridge is idle, a command write to offset 4 with data bits [1:0] = 01 starts a downstream read (`ds_req`=1, `ds_we`=0). Bits [1:0] = 10 start a downstream write (`ds_req`=1, `ds_we`=1). The request appears in the cycle after the command write.
- R3: Status bits [1:0] read 01 while a read is pending and 10 while a write is pending. They read 00 when idle. Status bits [7:2] always read 0.
- R4: On a read, the byte on `ds_rdata` in the cycle in which `ds_ack` is high is stored and shows at offset 3 from the next cycle onward.
- R5: During a transfer, `ds_addr` equals {offset 1, offset 0} and `ds_wdata` equals the offset 2 byte.
- R6: `ds_req`, `ds_we`, `ds_addr` and `ds_wdata` stay stable while `ds_req` is high without `ds_ack`. `ds_req` falls in the cycle after the acknowledge.
- R7: While a transfer is pending, host writes to offsets 0, 1, 2 and 4 are ignored. The transfer in progress continues unchanged, and no second transfer follows it.
- R8: A command whose bits [1:0] are 00 or 11 launches no transfer. Status stays 00 and `ds_req` stays low.
- R9: If `ds_ack` has not been seen in TIMEOUT consecutive request cycles, the transfer ends, status returns to 00, and a read stores 0xFF at offset 3. An acknowledge that arrives in the last allowed cycle still completes the transfer normally.
- R10: Offsets 0, 1 and 2 keep their values across transfers, so a repeated access needs only a new command write.
- R11: After reset, every register reads 0x00, status is idle and `ds_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write (with host_sel) |
| host_off | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_off (combinational) |
| ds_req | output | 1 | Downstream request |
| ds_we | output | 1 | Downstream direction, 1 = write |
| ds_addr | output | 16 | Downstream address |
| ds_wdata | output | 8 | Downstream write data |
| ds_ack | input | 1 | Downstream acknowledge |
| ds_rdata | input | 8 | Downstream read data, valid with ds_ack |

## Verification
A host write takes effect at the clock edge on which it is sampled, so a command raises `ds_req` and a busy status one edge later. An acknowledge sampled at an edge drops `ds_req`, clears status and loads the read byte at that same edge. A timeout ends the transfer on the TIMEOUT-th edge after the start. The bench drives every input on the falling edge and advances its behavioural model on the rising edge. One nanosecond after each rising edge it compares all outputs, including the readback of the currently selected offset, against the model, so every result is checked in the first cycle in which it is due.

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge #(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        host_wr,
  input  logic [2:0]  host_off,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        ds_req,
  output logic        ds_we,
  output logic [15:0] ds_addr,
  output logic [7:0]  ds_wdata,
  input  logic        ds_ack,
  input  logic [7:0]  ds_rdata
);
  localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [7:0]    lo_q, hi_q, wd_q, rd_q;
  logic [1:0]    op_q;
  logic [CW-1:0] cnt_q;

  wire busy   = |op_q;
  wire hw     = host_sel & host_wr & ~busy;
  wire ctl_wr = hw && host_off == 3'd4;
  wire go_rd  = ctl_wr && host_wdata[1:0] == 2'b01;
  wire go_wr  = ctl_wr && host_wdata[1:0] == 2'b10;
  wire tmo    = busy && !ds_ack && cnt_q == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      op_q  <= '0;
      cnt_q <= '0;
    end else if (busy) begin
      if (ds_ack || tmo) begin
        op_q <= '0;
        if (op_q[0]) rd_q <= ds_ack ? ds_rdata : 8'hFF;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (hw && host_off == 3'd0) lo_q <= host_wdata;
      if (hw && host_off == 3'd1) hi_q <= host_wdata;
      if (hw && host_off == 3'd2) wd_q <= host_wdata;
      if (go_rd || go_wr) begin
        op_q  <= {go_wr, go_rd};
        cnt_q <= '0;
      end
    end
  end

  always_comb begin
    case (host_off)
      3'd0:    host_rdata = lo_q;
      3'd1:    host_rdata = hi_q;
      3'd2:    host_rdata = wd_q;
      3'd3:    host_rdata = rd_q;
      3'd5:    host_rdata = {6'b0, op_q};
      default: host_rdata = 8'h00;
    endcase
  end

  assign ds_req   = busy;
  assign ds_we    = op_q[1];
  assign ds_addr  = {hi_q, lo_q};
  assign ds_wdata = wd_q;

  assert_read_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_req && host_sel && host_wr && host_off == 3'd4 && host_wdata[1:0] == 2'b01)
      |=> (ds_req && !ds_we));

  assert_write_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_req && host_sel && host_wr && host_off == 3'd4 && host_wdata[1:0] == 2'b10)
      |=> (ds_req && ds_we));

  assert_bad_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_req && host_sel && host_wr && host_off == 3'd4 &&
     (host_wdata[1:0] == 2'b00 || host_wdata[1:0] == 2'b11)) |=> !ds_req);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_ack) |=> (!ds_req ||
      ($stable(ds_addr) && $stable(ds_wdata) && $stable(ds_we))));

  assert_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && ds_ack) |=> !ds_req);

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && ds_ack && !ds_we) |=> (rd_q == $past(ds_rdata)));

  assert_timeout_ff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_ack && !ds_we && cnt_q == LAST) |=> (!ds_req && rd_q == 8'hFF));

  assert_busy_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_req && !ds_ack && cnt_q != LAST) |=> (ds_req && $stable(ds_addr)));
endmodule

// File: tb/test_ind_reg_bridge.sv
module test_ind_reg_bridge;
  localparam int TO = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0, host_wr = 1'b0;
  logic [2:0]  host_off = 3'd0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        ds_req, ds_we;
  logic [15:0] ds_addr;
  logic [7:0]  ds_wdata;
  logic        ds_ack = 1'b0;
  logic [7:0]  ds_rdata = 8'h00;

  ind_reg_bridge #(.TIMEOUT(TO)) i_ind_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_off(host_off), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .ds_ack(ds_ack), .ds_rdata(ds_rdata));

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // reference model and downstream memory
  logic [7:0] mem [256];
  int m_op, m_cnt;
  logic [7:0] m_lo, m_hi, m_wd, m_rd;
  int ack_dly = 2;
  int rcnt = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  function automatic logic [7:0] exp_view(logic [2:0] off);
    case (off)
      3'd0: return m_lo;
      3'd1: return m_hi;
      3'd2: return m_wd;
      3'd3: return m_rd;
      3'd5: return (m_op == 1) ? 8'h01 : (m_op == 2) ? 8'h02 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_op = 0; m_cnt = 0; m_lo = 0; m_hi = 0; m_wd = 0; m_rd = 0;
    end else if (m_op != 0) begin
      if (ds_ack) begin
        if (m_op == 1) m_rd = ds_rdata; else mem[m_lo] = m_wd;
        m_op = 0;
      end else if (m_cnt == TO - 1) begin
        if (m_op == 1) m_rd = 8'hFF;
        m_op = 0;
      end else m_cnt++;
    end else if (host_sel && host_wr) begin
      case (host_off)
        3'd0: m_lo = host_wdata;
        3'd1: m_hi = host_wdata;
        3'd2: m_wd = host_wdata;
        3'd4: if (host_wdata[1:0] == 2'b01) begin m_op = 1; m_cnt = 0; end
              else if (host_wdata[1:0] == 2'b10) begin m_op = 2; m_cnt = 0; end
        default: ;
      endcase
    end
    #1;
    if (rst_n) begin
      chk("R6 req", ds_req, m_op != 0);
      if (m_op != 0) begin
        chk("R2 direction", ds_we, m_op == 2);
        chk("R5 addr", ds_addr, {m_hi, m_lo});
        chk("R5 wdata", ds_wdata, m_wd);
      end
      chk(host_off == 3'd5 ? "R3 status" : host_off == 3'd3 ? "R4 rdata" : "R1 view",
          host_rdata, exp_view(host_off));
    end
  end

  // downstream responder
  always @(negedge clk) begin
    if (!rst_n || !ds_req) begin
      ds_ack = 1'b0; rcnt = 0;
    end else begin
      ds_ack = (rcnt == ack_dly);
      ds_rdata = mem[ds_addr[7:0]] ^ ds_addr[15:8];
      rcnt++;
    end
  end

  task automatic hwrite(logic [2:0] off, logic [7:0] d);
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_off = off; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic hcheck(string tag, logic [2:0] off, logic [7:0] exp);
    @(negedge clk);
    host_off = off;
    #1 chk(tag, host_rdata, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    host_off = 3'd5;
    for (int k = 0; k < 200; k++) begin
      @(posedge clk); #1;
      if (host_rdata[1:0] == 2'b00) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk("watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    for (int o = 0; o < 8; o++) hcheck("R11 reset view", 3'(o), 8'h00);
    chk("R11 req low", ds_req, 0);

    // R1 register readback
    hwrite(3'd0, 8'h34); hwrite(3'd1, 8'h12); hwrite(3'd2, 8'hA5);
    hcheck("R1 lo", 3'd0, 8'h34);
    hcheck("R1 hi", 3'd1, 8'h12);
    hcheck("R1 wd", 3'd2, 8'hA5);
    hcheck("R1 ctl reads zero", 3'd4, 8'h00);

    // R2/R3/R5 write
    ack_dly = 3;
    hwrite(3'd4, 8'h02);
    #1 chk("R2 write start", {ds_req, ds_we}, 2'b11);
    host_off = 3'd5; #1 chk("R3 write busy", host_rdata, 8'h02);
    wait_idle();
    chk("R3 idle after write", host_rdata, 8'h00);

    // R2/R3/R4 read back written byte (A5 ^ 12)
    hwrite(3'd4, 8'h01);
    #1 chk("R2 read start", {ds_req, ds_we}, 2'b10);
    host_off = 3'd5; #1 chk("R3 read busy", host_rdata, 8'h01);
    wait_idle();
    hcheck("R4 read data", 3'd3, 8'hB7);

    // R10 repeat with only a command write, different high byte
    hwrite(3'd1, 8'h00);
    ack_dly = 0;
    hwrite(3'd4, 8'h01);
    wait_idle();
    hcheck("R10 repeat read", 3'd3, 8'hA5);
    hcheck("R10 wd kept", 3'd2, 8'hA5);

    // R7 writes ignored while busy
    ack_dly = 5;
    hwrite(3'd4, 8'h01);
    hwrite(3'd0, 8'h99);
    hwrite(3'd2, 8'h11);
    hwrite(3'd4, 8'h02);
    wait_idle();
    repeat (3) @(negedge clk);
    #1 chk("R7 no second transfer", ds_req, 0);
    hcheck("R7 lo unchanged", 3'd0, 8'h34);
    hcheck("R7 wd unchanged", 3'd2, 8'hA5);

    // R8 bad commands
    hwrite(3'd4, 8'h00);
    #1 chk("R8 cmd 00", ds_req, 0);
    hwrite(3'd4, 8'hFF);
    #1 chk("R8 cmd 11", ds_req, 0);
    hcheck("R8 status idle", 3'd5, 8'h00);

    // R9 ack in last allowed cycle wins
    ack_dly = TO - 1;
    hwrite(3'd4, 8'h01);
    wait_idle();
    hcheck("R9 late ack data", 3'd3, 8'hA5);

    // R9 timeout read and write
    ack_dly = 1000;
    hwrite(3'd4, 8'h01);
    wait_idle();
    hcheck("R9 timeout read FF", 3'd3, 8'hFF);
    hwrite(3'd2, 8'h5A);
    hwrite(3'd4, 8'h02);
    wait_idle();
    hcheck("R9 write timeout idle", 3'd5, 8'h00);
    ack_dly = 1;
    hwrite(3'd4, 8'h01);
    wait_idle();
    hcheck("R9 timed-out write not stored", 3'd3, 8'hA5);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule